// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block turns one-shot cycle requests into the pin-level bus cycles of a small processor. The processor has an 8-bit bus that carries the low address byte and then data on the same lines, plus a separate upper address byte. A request names the cycle type, a 16-bit address and the write data. The controller steps through an idle clock and then the states T1, T2, any wait states, T3 and, for an opcode fetch only, T4. On these states it drives the address latch enable, the three status lines and the active-low read, write and interrupt-acknowledge strobes. It also decodes the four combined memory/I-O command strobes.

Outside logic latches the low address byte while the latch enable is high. A slow device stretches a cycle by holding the ready input low. At the end of each cycle the block gives a one-clock completion pulse and, for read-type cycles, the byte it captured from the bus. The pad-level bus is split into an output, an output enable and an input. Joining them into tri-state pads happens outside this block.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request: the latch enable is low, all seven active-low strobes are high, `ad_oe` is 0, and `busy` and `done` are 0.
- R2: The cycle type code on `req_type` is 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge. From T1 to the last state of the cycle, {`io_m`,`s1`,`s0`} shows 011, 010, 001, 110, 101 and 111 respectively. Outside a cycle it shows 000.
- R3: A request with `req_valid` high and a type code of 0 to 5 is accepted at a clock edge where `busy` is low. Exactly one clock with `busy` high and the latch enable low follows, then T1. Codes 6 and 7 are ignored, and so is any request made while `busy` is high.
- R4: In T1 the latch enable is high for exactly one clock, `ad_out` carries the low address byte with `ad_oe` = 1, and `a_hi` carries the upper address byte. `a_hi` keeps that value through T3.
- R5: From T2 through T3, `rd_n` is low for opcode fetch, memory read and I/O read. `wr_n` is low for the two write types. `inta_n` is low, instead of `rd_n`, for interrupt acknowledge. At most one of the three is ever low.
- R6: From T2 through T3 of a write, `ad_out` carries the write data with `ad_oe` = 1. For every other type `ad_oe` is 0 in these states.
- R7: `ready` is sampled at the end of T2 and at the end of each wait state. Every low sample adds one wait state, with the strobe held low and the address and status unchanged.
- R8: An opcode fetch adds a T4 state after T3. In T4 all strobes are high, `ad_oe` is 0 and `a_hi` is 0.
- R9: For read-type cycles and interrupt acknowledge, `ad_in` is captured at the end of T3 and shown on `rd_data`. `done` is high for the one clock after the last state of the cycle, and `busy` is low in that same clock.
- R10: For I/O read and I/O write, the low byte of `req_addr` is the port number. It appears on both `a_hi` and the low address byte, and the upper byte of `req_addr` is ignored.
- R11: `memr_n` is low exactly when `rd_n` and `io_m` are low. `memw_n` is low exactly when `wr_n` and `io_m` are low. `iord_n` and `iowr_n` are the same with `io_m` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request |
| req_type | input | 3 | Cycle type code |
| req_addr | input | 16 | Cycle address (low byte is the port number for I/O) |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | A cycle is in progress; requests are ignored |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Byte captured at the end of T3 |
| ready | input | 1 | Wait-state control; low stretches the cycle |
| a_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Multiplexed address/data lines, outgoing value |
| ad_oe | output | 1 | Output enable for the multiplexed lines |
| ad_in | input | 8 | Multiplexed address/data lines, incoming value |
| ale | output | 1 | Address latch enable |
| io_m | output | 1 | Status: high for I/O and interrupt acknowledge |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| memr_n | output | 1 | Memory read command, active low |
| memw_n | output | 1 | Memory write command, active low |
| iord_n | output | 1 | I/O read command, active low |
| iowr_n | output | 1 | I/O write command, active low |

## Verification
The properties assume that reset starts every run. They also assume that `req_valid`, `req_type` and `ready` are stable around each rising edge, because the controller samples them only there. The bench changes every input on the falling edge. It holds `ready` low for exactly the number of wait states it expects, releases it before the sampling edge that should end the cycle, and keeps `ad_in` at the expected read byte for the whole cycle. Requests that must be ignored (reserved codes, requests during a cycle) are driven only in clocks where acceptance would be visible as an extra latch-enable pulse.

// File: rtl/busc_pkg.sv
package busc_pkg;

    typedef enum logic [2:0] {
        CYC_FETCH = 3'd0,
        CYC_MRD   = 3'd1,
        CYC_MWR   = 3'd2,
        CYC_IORD  = 3'd3,
        CYC_IOWR  = 3'd4,
        CYC_INTA  = 3'd5
    } cyc_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAP,
        PH_T1,
        PH_T2,
        PH_TW,
        PH_T3,
        PH_T4
    } phase_e;

    localparam logic [2:0] LAST_CODE = 3'd5;

    // {io_m, s1, s0}
    function automatic logic [2:0] status_of(cyc_e c);
        case (c)
            CYC_FETCH: return 3'b011;
            CYC_MRD:   return 3'b010;
            CYC_MWR:   return 3'b001;
            CYC_IORD:  return 3'b110;
            CYC_IOWR:  return 3'b101;
            default:   return 3'b111;
        endcase
    endfunction

    function automatic logic uses_rd(cyc_e c);
        return (c == CYC_FETCH) || (c == CYC_MRD) || (c == CYC_IORD);
    endfunction

    function automatic logic uses_wr(cyc_e c);
        return (c == CYC_MWR) || (c == CYC_IOWR);
    endfunction

    function automatic logic is_port(cyc_e c);
        return (c == CYC_IORD) || (c == CYC_IOWR);
    endfunction

endpackage

// File: rtl/busc_seq.sv
module busc_seq
    import busc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_type,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ready,
    input  logic [DW-1:0] ad_in,
    output phase_e        phase,
    output cyc_e          cyc,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          busy
);
    localparam int REP = AW / DW;

    typedef struct packed {
        phase_e        phase;
        cyc_e          cyc;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          done;
    } seq_s;

    seq_s st_q, st_d;
    cyc_e new_cyc;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        new_cyc   = cyc_e'(req_type);
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid && (req_type <= LAST_CODE)) begin
                    st_d.phase = PH_GAP;
                    st_d.cyc   = new_cyc;
                    st_d.addr  = is_port(new_cyc) ? {REP{req_addr[DW-1:0]}} : req_addr;
                    st_d.wdata = req_wdata;
                end
            end
            PH_GAP: st_d.phase = PH_T1;
            PH_T1:  st_d.phase = PH_T2;
            PH_T2, PH_TW: st_d.phase = ready ? PH_T3 : PH_TW;
            PH_T3: begin
                if (!uses_wr(st_q.cyc)) st_d.rdata = ad_in;
                if (st_q.cyc == CYC_FETCH) begin
                    st_d.phase = PH_T4;
                end else begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            PH_T4: begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cyc: CYC_FETCH, addr: '0, wdata: '0, rdata: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase   = st_q.phase;
    assign cyc     = st_q.cyc;
    assign addr    = st_q.addr;
    assign wdata   = st_q.wdata;
    assign rd_data = st_q.rdata;
    assign done    = st_q.done;
    assign busy    = (st_q.phase != PH_IDLE);

endmodule

// File: rtl/busc_pins.sv
module busc_pins
    import busc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  phase_e           phase,
    input  cyc_e             cyc,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [AW-DW-1:0] a_hi,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic             ale,
    output logic             io_m,
    output logic             s1,
    output logic             s0,
    output logic             rd_n,
    output logic             wr_n,
    output logic             inta_n
);
    logic in_cycle, addr_ph, strobe_ph, wr_data_ph;

    always_comb begin
        in_cycle   = phase inside {PH_T1, PH_T2, PH_TW, PH_T3, PH_T4};
        addr_ph    = phase inside {PH_T1, PH_T2, PH_TW, PH_T3};
        strobe_ph  = phase inside {PH_T2, PH_TW, PH_T3};
        wr_data_ph = strobe_ph && uses_wr(cyc);

        {io_m, s1, s0} = in_cycle ? status_of(cyc) : 3'b000;
        ale    = (phase == PH_T1);
        a_hi   = addr_ph ? addr[AW-1:DW] : '0;
        ad_oe  = ale || wr_data_ph;
        ad_out = ale ? addr[DW-1:0] : (wr_data_ph ? wdata : '0);
        rd_n   = !(strobe_ph && uses_rd(cyc));
        wr_n   = !wr_data_ph;
        inta_n = !(strobe_ph && (cyc == CYC_INTA));
    end

endmodule

// File: rtl/busc_cmd_dec.sv
module busc_cmd_dec (
    input  logic rd_n,
    input  logic wr_n,
    input  logic io_m,
    output logic memr_n,
    output logic memw_n,
    output logic iord_n,
    output logic iowr_n
);
    always_comb begin
        memr_n = rd_n | io_m;
        memw_n = wr_n | io_m;
        iord_n = rd_n | !io_m;
        iowr_n = wr_n | !io_m;
    end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import busc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_type,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    input  logic             ready,
    output logic [AW-DW-1:0] a_hi,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_in,
    output logic             ale,
    output logic             io_m,
    output logic             s1,
    output logic             s0,
    output logic             rd_n,
    output logic             wr_n,
    output logic             inta_n,
    output logic             memr_n,
    output logic             memw_n,
    output logic             iord_n,
    output logic             iowr_n
);
    phase_e        phase;
    cyc_e          cyc;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;

    busc_seq #(.AW(AW), .DW(DW)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_type(req_type),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .ad_in(ad_in),
        .phase(phase), .cyc(cyc), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .done(done), .busy(busy)
    );

    busc_pins #(.AW(AW), .DW(DW)) pins_i (
        .phase(phase), .cyc(cyc), .addr(addr), .wdata(wdata),
        .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
        .io_m(io_m), .s1(s1), .s0(s0),
        .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n)
    );

    busc_cmd_dec dec_i (
        .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
        .memr_n(memr_n), .memw_n(memw_n), .iord_n(iord_n), .iowr_n(iowr_n)
    );

endmodule

// File: rtl/bus_cycle_ctrl_chk.sv
module bus_cycle_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ale,
    input logic ad_oe,
    input logic io_m,
    input logic s1,
    input logic s0,
    input logic rd_n,
    input logic wr_n,
    input logic inta_n
);
    logic strobe;
    assign strobe = !rd_n || !wr_n || !inta_n;

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rd_n, ~wr_n, ~inta_n}) <= 1);

    assert_ale_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_ale_drives_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    assert_strobe_after_ale_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> strobe);

    assert_read_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !inta_n) |-> !ad_oe);

    assert_write_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    assert_status_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(strobe)) |-> $stable({io_m, s1, s0}));

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> done);

endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ale(ale),
    .ad_oe(ad_oe), .io_m(io_m), .s1(s1), .s0(s0),
    .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n)
);

// File: tb/bus_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_type = 3'd0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       ready = 1'b1;
    logic [7:0] ad_in = '0;
    logic       busy, done, ad_oe, ale, io_m, s1, s0, rd_n, wr_n, inta_n;
    logic       memr_n, memw_n, iord_n, iowr_n;
    logic [7:0] rd_data, a_hi, ad_out;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int         typ;
        logic [15:0] addr;
        logic [7:0] wd;
        logic [7:0] rd;
        int         waits;
    } item_t;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    bus_cycle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .ready(ready), .a_hi(a_hi), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .io_m(io_m), .s1(s1), .s0(s0),
        .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .memr_n(memr_n),
        .memw_n(memw_n), .iord_n(iord_n), .iowr_n(iowr_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic logic [2:0] code_of(int t);
        case (t)
            0: return 3'b011;
            1: return 3'b010;
            2: return 3'b001;
            3: return 3'b110;
            4: return 3'b101;
            default: return 3'b111;
        endcase
    endfunction

    // Driver: pushes the expected item and runs the handshake and READY.
    task automatic run(input int t, input logic [15:0] a, input logic [7:0] wd,
                       input logic [7:0] rd, input int w);
        item_t it;
        while (busy) @(negedge clk);
        it.typ = t; it.addr = a; it.wd = wd; it.rd = rd; it.waits = w;
        exp_q.push_back(it);
        req_type = 3'(t); req_addr = a; req_wdata = wd; ad_in = rd;
        ready = (w == 0);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !ale, "R3 idle clock after accept", {busy, ale}, 2'b10);
        @(negedge clk);
        @(negedge clk);
        repeat (w) @(negedge clk);
        ready = 1'b1;
    endtask

    // Monitor: pops an item on each T1 and follows the cycle state by state.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && ale) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected cycle", 1, 0);
                end else begin
                    item_t e;
                    logic [7:0] ehi, elo;
                    bit isrd, iswr, isia;
                    e = exp_q.pop_front();
                    ehi = (e.typ == 3 || e.typ == 4) ? e.addr[7:0] : e.addr[15:8];
                    elo = e.addr[7:0];
                    isrd = (e.typ == 0 || e.typ == 1 || e.typ == 3);
                    iswr = (e.typ == 2 || e.typ == 4);
                    isia = (e.typ == 5);
                    chk(a_hi == ehi, (e.typ == 3 || e.typ == 4) ? "R10 port on upper byte" : "R4 upper address", a_hi, ehi);
                    chk(ad_out == elo && ad_oe, "R4 low address in T1", {ad_oe, ad_out}, {1'b1, elo});
                    chk({io_m, s1, s0} == code_of(e.typ), "R2 status in T1", {io_m, s1, s0}, code_of(e.typ));
                    chk(rd_n && wr_n && inta_n, "R5 strobes idle in T1", {rd_n, wr_n, inta_n}, 3'b111);
                    for (int k = 0; k < e.waits + 2; k++) begin
                        @(negedge clk);
                        chk({rd_n, wr_n, inta_n} == {!isrd, !iswr, !isia},
                            k == 0 ? "R5 strobe in T2" : "R7 strobe held in wait/T3",
                            {rd_n, wr_n, inta_n}, {!isrd, !iswr, !isia});
                        chk(ad_oe == iswr, "R6 bus direction", ad_oe, iswr);
                        if (iswr) chk(ad_out == e.wd, "R6 write data", ad_out, e.wd);
                        chk(a_hi == ehi && !ale, "R4 upper address held", a_hi, ehi);
                        chk({io_m, s1, s0} == code_of(e.typ), "R2 status held", {io_m, s1, s0}, code_of(e.typ));
                        chk({memr_n, memw_n, iord_n, iowr_n} ==
                            {!(isrd && !io_m), !(iswr && !io_m), !(isrd && io_m), !(iswr && io_m)},
                            "R11 decoded commands", {memr_n, memw_n, iord_n, iowr_n},
                            {!(isrd && !io_m), !(iswr && !io_m), !(isrd && io_m), !(iswr && io_m)});
                        chk(!done, "R9 no early done", done, 0);
                    end
                    if (e.typ == 0) begin
                        @(negedge clk);
                        chk(rd_n && wr_n && inta_n && !ad_oe && a_hi == 8'h00 && busy,
                            "R8 fetch T4", {busy, ad_oe, rd_n, wr_n, inta_n, a_hi}, {1'b1, 1'b0, 3'b111, 8'h00});
                        chk({io_m, s1, s0} == 3'b011, "R2 status in T4", {io_m, s1, s0}, 3'b011);
                    end
                    @(negedge clk);
                    chk(done && !busy, "R9 done pulse", {done, busy}, 2'b10);
                    chk({io_m, s1, s0} == 3'b000, "R2 idle status", {io_m, s1, s0}, 3'b000);
                    if (!iswr) chk(rd_data == e.rd, "R9 read data", rd_data, e.rd);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk(!ale && rd_n && wr_n && inta_n && !ad_oe && !busy && !done,
            "R1 state in reset", {ale, rd_n, wr_n, inta_n, ad_oe, busy, done}, 7'b0111000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ale && memr_n && memw_n && iord_n && iowr_n && !ad_oe && !busy && !done,
            "R1 state after reset", {ale, memr_n, memw_n, iord_n, iowr_n, ad_oe, busy}, 7'b0111100);

        run(0, 16'h2000, 8'h00, 8'h3E, 0);
        run(1, 16'h2001, 8'h00, 8'h32, 0);
        run(2, 16'h8805, 8'hA5, 8'hFF, 2);
        run(3, 16'h9930, 8'h00, 8'h5C, 1);
        run(4, 16'h1250, 8'h77, 8'h00, 0);
        run(5, 16'h0038, 8'h00, 8'hC7, 0);
        run(0, 16'hFFF0, 8'h00, 8'h81, 3);

        // R3: reserved codes 6 and 7 are ignored
        while (busy) @(negedge clk);
        for (int c = 6; c < 8; c++) begin
            req_type = 3'(c); req_addr = 16'h4444; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            @(negedge clk);
            chk(!busy && !ale, "R3 reserved code ignored", {busy, ale}, 2'b00);
        end

        // R3: a request during a cycle is ignored
        run(1, 16'h1234, 8'h00, 8'h9A, 2);
        req_type = 3'd2; req_addr = 16'h5555; req_wdata = 8'h11; req_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(!busy, "R3 request during cycle ignored", busy, 0);
        end

        // back-to-back cycles
        run(4, 16'h00FF, 8'h3C, 8'h00, 0);
        run(2, 16'h0000, 8'hFF, 8'h00, 1);
        run(3, 16'hAB07, 8'h00, 8'h07, 0);

        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all cycles seen", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule